// File: doc/BRIEF.md
# Dead-Time Complementary Gate Sequencer

This block produces the two gate commands of a half-bridge: one for the low-side switch and one for the high-side switch. While the run enable is high, an internal cycle repeats. Each cycle has a charge phase, whose length comes from a period input, and then a fixed dead phase. A toggle flips at the end of every cycle and routes the charge phases alternately to the low and high outputs. Each output therefore switches at half the internal cycle rate, with equal on-times on both sides. Both outputs are held low through every dead phase.

Every start begins on the low side, so a bootstrap supply is refilled before the high side is driven. Dropping the run enable silences both outputs on the next clock edge and returns the toggle to the low side. The dead length is fixed by a variant parameter: a slow variant of about 600 ns and a fast variant of about 300 ns, counted in clock cycles. Both output paths pass through the same number of register stages, so their latencies match. A digital under-voltage flag for the floating supply blocks the high output without disturbing the sequence.

Top module: `gate_sequencer`

## Requirements
- R1: While reset is asserted, both gateLow and gateHigh are 0.
- R2: When runEn is first sampled high from idle at clock edge E, gateLow rises after edge E+MATCH_STAGES (E+1 by default). The first active pulse after any start always goes to gateLow.
- R3: Each charge phase lasts periodIn clock cycles. periodIn is captured when the charge phase begins, so a change during a cycle only affects the next charge phase.
- R4: A periodIn value of 0 is treated as a charge length of 1 cycle.
- R5: Between two consecutive active pulses, both outputs are low for exactly DEAD_CYCLES cycles. This is 75 by default, or 38 when FAST_VARIANT is 1.
- R6: Active pulses alternate strictly: low, high, low, high, and so on.
- R7: gateLow and gateHigh are never 1 in the same cycle.
- R8: When runEn is sampled low, both outputs are 0 after that edge. The toggle returns to the low side, so the next start again begins with gateLow, even when the stop fell inside a high-side pulse.
- R9: While uvFlag is 1, gateHigh is 0 in the same cycle. gateLow and the timing of all phases are unaffected.
- R10: Both output paths have equal latency. A high-side pulse begins exactly DEAD_CYCLES cycles after the preceding low-side pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Run enable; low stops both outputs |
| periodIn | input | PERIOD_W | Charge length in clock cycles (0 acts as 1) |
| uvFlag | input | 1 | Floating-supply under-voltage flag; blocks gateHigh |
| gateLow | output | 1 | Low-side gate command |
| gateHigh | output | 1 | High-side gate command |

## Verification
The hardest situation to reach is a stop that lands in the middle of a high-side charge phase, followed by a restart. Only this case shows whether the toggle really returns to the low side, and it needs the stop edge placed on an exact cycle count. The driver task computes every cycle of the expected waveform in advance. It then deasserts runEn only when the scoreboard queue drains, which places the stop on a chosen cycle inside a chosen pulse. A period change is applied one cycle into the first charge phase. This shows that capture happens only at a phase boundary.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CHARGE = 2'd1,
    PH_DEAD   = 2'd2
  } phase_t;

  // strobes from the sequencing control into the datapath
  typedef struct packed {
    logic loadCharge;  // capture period, start a charge phase
    logic loadDead;    // start a dead phase
    logic flipSide;    // hand the next charge to the other switch
    logic clrSide;     // stop: return to low side, flush outputs
    logic charging;    // current cycle belongs to a charge phase
  } seq_strobe_t;

endpackage

// File: rtl/gseq_ctrl.sv
module gseq_ctrl
  import gseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        cntZero,
  output seq_strobe_t strb
);

  phase_t phase;
  phase_t phaseNxt;

  always_comb begin
    strb     = '0;
    phaseNxt = phase;
    if (!runEn) begin
      phaseNxt     = PH_IDLE;
      strb.clrSide = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNxt        = PH_CHARGE;
          strb.loadCharge = 1'b1;
        end
        PH_CHARGE: begin
          if (cntZero) begin
            phaseNxt      = PH_DEAD;
            strb.loadDead = 1'b1;
          end
        end
        PH_DEAD: begin
          if (cntZero) begin
            phaseNxt        = PH_CHARGE;
            strb.loadCharge = 1'b1;
            strb.flipSide   = 1'b1;
          end
        end
        default: phaseNxt = PH_IDLE;
      endcase
    end
    strb.charging = (phase == PH_CHARGE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  AST_DEAD_FOLLOWS_CHARGE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CHARGE && cntZero && runEn) |=> (phase == PH_DEAD)); // R5

  AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (phase == PH_IDLE)); // R8

endmodule

// File: rtl/gseq_dpath.sv
module gseq_dpath
  import gseq_pkg::*;
#(
  parameter int PERIOD_W     = 8,
  parameter int DEAD_CYCLES  = 75,
  parameter int MATCH_STAGES = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic                uvFlag,
  input  seq_strobe_t         strb,
  output logic                cntZero,
  output logic                gateLow,
  output logic                gateHigh
);

  localparam int DEAD_W = $clog2(DEAD_CYCLES + 1);
  localparam int CNT_W  = (PERIOD_W > DEAD_W) ? PERIOD_W : DEAD_W;
  localparam int LAST   = MATCH_STAGES - 1;

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] chargeLoad;
  logic             sideHigh;
  logic [1:0]       sideCmd;
  logic [1:0]       sideOut;

  // period 0 behaves as 1: load terminal count directly
  assign chargeLoad = (periodIn == '0) ? '0 : CNT_W'(periodIn - PERIOD_W'(1));
  assign cntZero    = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      sideHigh <= 1'b0;
    end else begin
      if (strb.clrSide)         phaseCnt <= '0;
      else if (strb.loadCharge) phaseCnt <= chargeLoad;
      else if (strb.loadDead)   phaseCnt <= CNT_W'(DEAD_CYCLES - 1);
      else if (!cntZero)        phaseCnt <= phaseCnt - CNT_W'(1);

      if (strb.clrSide)       sideHigh <= 1'b0;
      else if (strb.flipSide) sideHigh <= ~sideHigh;
    end
  end

  assign sideCmd[0] = strb.charging & ~sideHigh;
  assign sideCmd[1] = strb.charging &  sideHigh;

  // identical register chain on both sides keeps their latency matched
  for (genvar g = 0; g < 2; g++) begin : gSide
    logic [MATCH_STAGES-1:0] stagePipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stagePipe <= '0;
      end else if (strb.clrSide) begin
        stagePipe <= '0;
      end else begin
        for (int i = LAST; i > 0; i--) stagePipe[i] <= stagePipe[i-1];
        stagePipe[0] <= sideCmd[g];
      end
    end
    assign sideOut[g] = stagePipe[LAST];
  end

  assign gateLow  = sideOut[0];
  assign gateHigh = sideOut[1] & ~uvFlag;

  AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadCharge && !strb.flipSide) |=> !sideHigh); // R2

  AST_SIDES_EXCLUSIVE_PIPE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(sideOut) <= 1); // R7

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
  parameter int PERIOD_W      = 8,
  parameter bit FAST_VARIANT  = 1'b0,
  parameter int DEAD_SLOW_CYC = 75,
  parameter int DEAD_FAST_CYC = 38,
  parameter int MATCH_STAGES  = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic                uvFlag,
  output logic                gateLow,
  output logic                gateHigh
);

  localparam int DEAD_CYCLES = FAST_VARIANT ? DEAD_FAST_CYC : DEAD_SLOW_CYC;

  gseq_pkg::seq_strobe_t strb;
  logic                  cntZero;

  gseq_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .cntZero (cntZero),
    .strb    (strb)
  );

  gseq_dpath #(
    .PERIOD_W     (PERIOD_W),
    .DEAD_CYCLES  (DEAD_CYCLES),
    .MATCH_STAGES (MATCH_STAGES)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .periodIn (periodIn),
    .uvFlag   (uvFlag),
    .strb     (strb),
    .cntZero  (cntZero),
    .gateLow  (gateLow),
    .gateHigh (gateHigh)
  );

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(gateLow && gateHigh)); // R7

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!gateLow && !gateHigh)); // R8

  AST_GAP_BEFORE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateHigh) |-> !$past(gateLow)); // R5

  AST_GAP_BEFORE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateLow) |-> !$past(gateHigh)); // R5

endmodule

// File: tb/test_gate_sequencer.sv
`timescale 1ns/1ps
module test_gate_sequencer;

  localparam int PW   = 8;
  localparam int DEAD = 75;

  typedef struct packed {
    logic       lo;
    logic       hi;
    logic [3:0] req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          runEn = 1'b0;
  logic [PW-1:0] periodIn = '0;
  logic          uvFlag = 1'b0;
  logic          gateLow;
  logic          gateHigh;

  int   nChecks = 0;
  int   nFails  = 0;
  exp_t sbq[$];

  always #4 clk = ~clk;

  gate_sequencer i_gate_sequencer (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .periodIn (periodIn),
    .uvFlag   (uvFlag),
    .gateLow  (gateLow),
    .gateHigh (gateHigh)
  );

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic push(input logic lo, input logic hi, input int r);
    exp_t e;
    e.lo  = lo;
    e.hi  = hi;
    e.req = 4'(r);
    sbq.push_back(e);
  endtask

  // monitor: one sample per cycle, after the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN) begin
        nChecks++;
        if (gateLow && gateHigh) begin
          nFails++;
          $display("FAIL R7: got lo=1 hi=1 expected at most one high");
        end
      end
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        nChecks++;
        if (gateLow !== e.lo || gateHigh !== e.hi) begin
          nFails++;
          $display("FAIL %s: got lo=%0b hi=%0b expected lo=%0b hi=%0b",
                   reqName(e.req), gateLow, gateHigh, e.lo, e.hi);
        end
      end
    end
  end

  // driver: predicts every cycle of a run, then stops it on a chosen cycle
  task automatic runBurst(input int p1, input int p2, input int halves,
                          input int extra, input bit uv);
    int  e1;
    int  e2;
    int  len;
    int  r;
    bit  hs;
    e1 = (p1 == 0) ? 1 : p1;
    e2 = (p2 == 0) ? 1 : p2;
    @(negedge clk);
    runEn    = 1'b1;
    periodIn = PW'(p1);
    uvFlag   = uv;
    push(1'b0, 1'b0, 2);                       // R2: one cycle of latency
    for (int h = 0; h < halves; h++) begin
      len = (h == 0) ? e1 : e2;
      hs  = h[0];
      for (int i = 0; i < len; i++) begin
        if (h == 0)                    r = 2;   // R2: low side first
        else if (hs && uv)             r = 9;   // R9: high blocked
        else if (hs && i == 0)         r = 10;  // R10: equal latency
        else if ((h == 0 ? p1 : p2) == 0) r = 4; // R4: zero acts as one
        else if (p1 != p2)             r = 3;   // R3: new period next phase
        else                           r = 6;   // R6: alternation
        push(!hs, hs && !uv, r);
      end
      for (int i = 0; i < DEAD; i++) push(1'b0, 1'b0, 5); // R5: dead gap
    end
    hs = halves[0];
    for (int i = 0; i < extra; i++) push(!hs, hs && !uv, 6);
    @(posedge clk);
    @(negedge clk);
    periodIn = PW'(p2);
    wait (sbq.size() == 0);
    @(negedge clk);
    runEn = 1'b0;
    for (int i = 0; i < 3; i++) push(1'b0, 1'b0, 8); // R8: immediate stop
    wait (sbq.size() == 0);
  endtask

  initial begin
    #1500000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: outputs quiet under reset, even with runEn high
    runEn = 1'b1;
    periodIn = PW'(4);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #2;
      nChecks++;
      if (gateLow !== 1'b0 || gateHigh !== 1'b0) begin
        nFails++;
        $display("FAIL R1: got lo=%0b hi=%0b expected lo=0 hi=0", gateLow, gateHigh);
      end
    end
    @(negedge clk);
    runEn = 1'b0;
    rstN  = 1'b1;
    repeat (2) @(posedge clk);

    runBurst(5, 5, 4, 2, 1'b0);   // steady run, stop inside a low pulse
    runBurst(3, 9, 3, 4, 1'b0);   // period change; stop inside a high pulse
    runBurst(6, 6, 2, 0, 1'b0);   // restart after high-side stop starts low
    runBurst(0, 0, 4, 0, 1'b0);   // zero period
    runBurst(4, 4, 4, 1, 1'b1);   // under-voltage blocks high side
    runBurst(1, 2, 5, 1, 1'b0);   // shortest charge, then change

    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule